// File: doc/BRIEF.md
# Network Wakeup Event Controller

This block decides when a network controller raises its power-management wake output. It does no packet parsing itself. Once per received packet it takes a one-cycle end-of-packet strobe together with the verdicts of logic upstream: a magic-pattern match flag, a flag saying that the standard address filter passed the packet, a vector of wakeup-filter match flags, and a flag that marks a packet received with errors. Packets marked with errors are dropped.

Two wake paths share one wake pin. The legacy path acts only on magic packets, and only while its enable bit is set. That enable is loaded from a configuration word read out of non-volatile memory, and software can also write it. A magic match always records a received status bit. If the assert-on-magic bit is also set, the match sets the power-management status bit and arms a held wake. The held wake lasts until software clears the received status, clears the assert-on-magic bit, or disables the legacy path. The second path needs two things at once: the address filter must pass the packet, and at least one filter flag that is enabled in the filter mask must be set. Such a match sets the power-management status bit. That status bit drives the pin only while the power-management enable bit is set.

Software reaches the control and status bits through a small register port. It has a write strobe, a 2-bit register select, 16-bit write data and a combinational read-data bus. The wake pin is registered.

Top module: `netwake_ctrl`

## Requirements
- R1: After reset, all four registers read as zero and `wake_o` is low.
- R2: The legacy enable (select 0, bit 0) changes only through `cfg_load`, which copies `cfg_apm_en`, or through a software write to select 0. If both happen in the same cycle, `cfg_load` wins. Packets never change the enable.
- R3: A magic flag has no effect unless `pkt_valid` is high, `pkt_err` is low and the legacy enable is set.
- R4: An accepted magic packet sets the magic-received status bit (select 1, bit 0), whatever the value of the assert-on-magic bit (select 0, bit 1).
- R5: An accepted magic packet with the assert-on-magic bit set also sets the PM status bit (select 3, bit 15). `wake_o` then rises after the second rising edge that follows the strobe.
- R6: A wake raised by a magic packet stays high until the magic-received bit is cleared, the assert-on-magic bit is cleared, or the legacy enable is cleared. `wake_o` falls after the second rising edge that follows the releasing write.
- R7: A packet sets the PM status bit through the filter path only if `pkt_addr_pass` is high and some bit of `pkt_filt_hit`, ANDed with the filter mask (select 2, low bits), is set.
- R8: In the filter path, `wake_o` follows the PM status bit only while the PM enable bit (select 3, bit 8) is set.
- R9: Status bits are cleared by writing a one to them. A set from a packet in the same cycle as a clear leaves the bit set.
- R10: Select 3, bits 1:0 hold a power-state code that reads back as written (2'b11 is low power). The legacy path wakes in every power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe: configuration word read from non-volatile memory |
| cfg_apm_en | input | 1 | Legacy enable value carried by that configuration word |
| pkt_valid | input | 1 | One-cycle end-of-packet strobe |
| pkt_err | input | 1 | Packet was received with errors |
| pkt_magic | input | 1 | Packet matched the magic pattern |
| pkt_addr_pass | input | 1 | Packet passed the standard address filter |
| pkt_filt_hit | input | NUM_FILT | Per-filter wakeup match flags |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 filter mask, 3 PM control/status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| wake_o | output | 1 | Registered wake output |

## Verification
The bench releases a held magic-packet wake in each of the three separate ways. A design that only watched the status bit would leave the pin stuck high after the assert-on-magic bit or the enable was cleared. It sends packets that pass only one of the two filter stages, or that hit only a masked-off filter. A design that ORs the stages, or ignores the mask, would set the status bit. It also lands a packet set and a software clear on the same edge, where a clear-priority design loses the event. Finally it checks the pin one cycle early and at the exact cycle it is due, which catches an extra or a missing register stage.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_FMASK = 2'd2,
    SEL_PMCS  = 2'd3
  } reg_sel_e;

  localparam int CTRL_APM_EN  = 0;
  localparam int CTRL_APM_PME = 1;
  localparam int STAT_MAGIC   = 0;
  localparam int PMCS_PME_EN  = 8;
  localparam int PMCS_PME_ST  = 15;

  // write-one-to-clear with set priority
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // two-stage filter rule: address filter AND any enabled filter hit
  function automatic logic filter_pass(input logic addr_ok, input logic any_enabled_hit);
    return addr_ok & any_enabled_hit;
  endfunction
endpackage

// File: rtl/wake_pkt_qual.sv
module wake_pkt_qual #(
  parameter int NUM_FILT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic                pkt_err,
  input  logic                pkt_magic,
  input  logic                pkt_addr_pass,
  input  logic [NUM_FILT-1:0] pkt_filt_hit,
  input  logic [NUM_FILT-1:0] filt_mask,
  input  logic                apm_en,
  output logic                apm_go,
  output logic                acpi_go
);
  import wake_pkg::*;

  logic pkt_ok;
  logic any_hit;

  assign pkt_ok  = pkt_valid & ~pkt_err;
  assign any_hit = |(pkt_filt_hit & filt_mask);
  assign apm_go  = pkt_ok & pkt_magic & apm_en;
  assign acpi_go = pkt_ok & filter_pass(pkt_addr_pass, any_hit);

  // R3: errored or non-strobed packets never qualify
  p_err_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err || !pkt_valid) |-> (!apm_go && !acpi_go));
  // R7: filter path needs the address filter
  p_acpi_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acpi_go |-> pkt_addr_pass);
endmodule

// File: rtl/wake_regs.sv
module wake_regs #(
  parameter int NUM_FILT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_load,
  input  logic                     cfg_apm_en,
  input  logic                     apm_go,
  input  logic                     acpi_go,
  input  logic                     reg_wr,
  input  logic [1:0]               reg_sel,
  input  logic [wake_pkg::REG_W-1:0] reg_wdata,
  output logic [wake_pkg::REG_W-1:0] reg_rdata,
  output logic                     apm_en,
  output logic [NUM_FILT-1:0]      filt_mask,
  output logic                     apm_hold,
  output logic                     pme_st,
  output logic                     pme_en
);
  import wake_pkg::*;

  logic       apm_en_q, apm_pme_q, magic_q, armed_q, pme_st_q, pme_en_q;
  logic [1:0] ps_q;
  logic [NUM_FILT-1:0] fmask_q;

  logic wr_ctrl, wr_stat, wr_fmask, wr_pmcs;
  logic clr_magic, clr_pme_st, pme_set;
  logic hold_now;
  logic unused_wdata;

  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_stat  = reg_wr && (reg_sel == SEL_STAT);
  assign wr_fmask = reg_wr && (reg_sel == SEL_FMASK);
  assign wr_pmcs  = reg_wr && (reg_sel == SEL_PMCS);

  assign clr_magic  = wr_stat & reg_wdata[STAT_MAGIC];
  assign clr_pme_st = wr_pmcs & reg_wdata[PMCS_PME_ST];
  assign pme_set    = (apm_go & apm_pme_q) | acpi_go;
  assign hold_now   = armed_q & magic_q & apm_pme_q & apm_en_q;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apm_en_q  <= 1'b0;
      apm_pme_q <= 1'b0;
      magic_q   <= 1'b0;
      armed_q   <= 1'b0;
      pme_st_q  <= 1'b0;
      pme_en_q  <= 1'b0;
      ps_q      <= 2'b00;
      fmask_q   <= '0;
    end else begin
      if (cfg_load)     apm_en_q <= cfg_apm_en;
      else if (wr_ctrl) apm_en_q <= reg_wdata[CTRL_APM_EN];
      if (wr_ctrl)  apm_pme_q <= reg_wdata[CTRL_APM_PME];
      if (wr_fmask) fmask_q   <= reg_wdata[NUM_FILT-1:0];
      if (wr_pmcs) begin
        pme_en_q <= reg_wdata[PMCS_PME_EN];
        ps_q     <= reg_wdata[1:0];
      end
      magic_q  <= w1c_next(magic_q, apm_go, clr_magic);
      pme_st_q <= w1c_next(pme_st_q, pme_set, clr_pme_st);
      armed_q  <= (apm_go & apm_pme_q) | hold_now;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[CTRL_APM_EN]  = apm_en_q;
        reg_rdata[CTRL_APM_PME] = apm_pme_q;
      end
      SEL_STAT:  reg_rdata[STAT_MAGIC] = magic_q;
      SEL_FMASK: reg_rdata[NUM_FILT-1:0] = fmask_q;
      default: begin
        reg_rdata[1:0]         = ps_q;
        reg_rdata[PMCS_PME_EN] = pme_en_q;
        reg_rdata[PMCS_PME_ST] = pme_st_q;
      end
    endcase
  end

  assign apm_en    = apm_en_q;
  assign filt_mask = fmask_q;
  assign apm_hold  = hold_now;
  assign pme_st    = pme_st_q;
  assign pme_en    = pme_en_q;

  // R2: enable moves only by config load or control write
  p_apm_en_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !wr_ctrl) |=> $stable(apm_en_q));
  // R9: packet set beats a same-cycle clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    apm_go |=> magic_q);
  // R7: a filter-path match always lands in PM status
  p_acpi_sets_st_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acpi_go |=> pme_st_q);
  // R4: magic-received only rises from an accepted magic packet
  p_magic_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!magic_q && !apm_go) |=> !magic_q);
endmodule

// File: rtl/wake_pin.sv
module wake_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic apm_hold,
  input  logic pme_st,
  input  logic pme_en,
  output logic wake_o
);
  logic wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= apm_hold | (pme_st & pme_en);
  end

  assign wake_o = wake_q;

  // R8: a pin not held by magic needs the PM enable
  p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !$past(apm_hold)) |-> $past(pme_en));
  // R6: once the magic hold drops and the PM term is off, the pin falls
  p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(apm_hold) && !(pme_st && pme_en)) |=> !wake_o);
endmodule

// File: rtl/netwake_ctrl.sv
module netwake_ctrl #(
  parameter int NUM_FILT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_load,
  input  logic                cfg_apm_en,
  input  logic                pkt_valid,
  input  logic                pkt_err,
  input  logic                pkt_magic,
  input  logic                pkt_addr_pass,
  input  logic [NUM_FILT-1:0] pkt_filt_hit,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [15:0]         reg_wdata,
  output logic [15:0]         reg_rdata,
  output logic                wake_o
);
  logic                apm_go, acpi_go, apm_en, apm_hold, pme_st, pme_en;
  logic [NUM_FILT-1:0] filt_mask;

  wake_pkt_qual #(.NUM_FILT(NUM_FILT)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_err(pkt_err), .pkt_magic(pkt_magic),
    .pkt_addr_pass(pkt_addr_pass), .pkt_filt_hit(pkt_filt_hit),
    .filt_mask(filt_mask), .apm_en(apm_en),
    .apm_go(apm_go), .acpi_go(acpi_go)
  );

  wake_regs #(.NUM_FILT(NUM_FILT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_apm_en(cfg_apm_en),
    .apm_go(apm_go), .acpi_go(acpi_go),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .apm_en(apm_en), .filt_mask(filt_mask), .apm_hold(apm_hold),
    .pme_st(pme_st), .pme_en(pme_en)
  );

  wake_pin u_pin (
    .clk(clk), .rst_n(rst_n),
    .apm_hold(apm_hold), .pme_st(pme_st), .pme_en(pme_en),
    .wake_o(wake_o)
  );
endmodule

// File: tb/tb_netwake_ctrl.sv
module tb_netwake_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0, cfg_apm_en = 1'b0;
  logic        pkt_valid = 1'b0, pkt_err = 1'b0, pkt_magic = 1'b0, pkt_addr_pass = 1'b0;
  logic [3:0]  pkt_filt_hit = 4'h0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        wake_o;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  netwake_ctrl #(.NUM_FILT(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_apm_en(cfg_apm_en),
    .pkt_valid(pkt_valid), .pkt_err(pkt_err), .pkt_magic(pkt_magic),
    .pkt_addr_pass(pkt_addr_pass), .pkt_filt_hit(pkt_filt_hit),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string req);
    reg_sel = sel;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pkt(input logic magic, input logic err, input logic addr,
                     input logic [3:0] hits, input logic valid);
    @(negedge clk);
    pkt_valid = valid; pkt_err = err; pkt_magic = magic;
    pkt_addr_pass = addr; pkt_filt_hit = hits;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_err = 1'b0; pkt_magic = 1'b0;
    pkt_addr_pass = 1'b0; pkt_filt_hit = 4'h0;
  endtask

  task automatic t_reset();
    rd(2'd0, 16'h0, "R1 ctrl");
    rd(2'd1, 16'h0, "R1 stat");
    rd(2'd2, 16'h0, "R1 fmask");
    rd(2'd3, 16'h0, "R1 pmcs");
    check("R1 wake", {15'h0, wake_o}, 16'h0);
  endtask

  task automatic t_cfg();
    @(negedge clk); cfg_load = 1'b1; cfg_apm_en = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
    rd(2'd0, 16'h1, "R2 cfg load 1");
    pkt(1'b1, 1'b0, 1'b1, 4'hF, 1'b1);
    rd(2'd0, 16'h1, "R2 packet no effect");
    wr(2'd1, 16'h1);
    @(negedge clk); cfg_load = 1'b1; cfg_apm_en = 1'b0;
    @(negedge clk); cfg_load = 1'b0;
    rd(2'd0, 16'h0, "R2 cfg load 0");
    @(negedge clk); cfg_load = 1'b1; cfg_apm_en = 1'b1;
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h0;
    @(negedge clk); cfg_load = 1'b0; reg_wr = 1'b0;
    rd(2'd0, 16'h1, "R2 cfg beats write");
    wr(2'd0, 16'h0);
    rd(2'd0, 16'h0, "R2 sw write 0");
  endtask

  task automatic t_gated();
    pkt(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    rd(2'd1, 16'h0, "R3 apm disabled");
    wr(2'd0, 16'h3);
    pkt(1'b1, 1'b1, 1'b0, 4'h0, 1'b1);
    rd(2'd1, 16'h0, "R3 errored packet");
    pkt(1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
    rd(2'd1, 16'h0, "R3 no strobe");
    @(negedge clk);
    check("R3 wake stays low", {15'h0, wake_o}, 16'h0);
  endtask

  task automatic t_status_only();
    wr(2'd0, 16'h1);
    pkt(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    rd(2'd1, 16'h1, "R4 magic status");
    rd(2'd3, 16'h0, "R4 no pme status");
    @(negedge clk);
    check("R4 no wake", {15'h0, wake_o}, 16'h0);
    wr(2'd1, 16'h1);
    rd(2'd1, 16'h0, "R9 w1c clear");
  endtask

  task automatic arm();
    wr(2'd0, 16'h3);
    pkt(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
  endtask

  task automatic t_apm_wake();
    wr(2'd3, 16'h0003);
    rd(2'd3, 16'h0003, "R10 power state readback");
    arm();
    check("R5 wake not early", {15'h0, wake_o}, 16'h0);
    rd(2'd3, 16'h8003, "R5 pme status");
    @(negedge clk);
    check("R5 wake in low power", {15'h0, wake_o}, 16'h1);
    repeat (5) @(negedge clk);
    check("R6 wake held", {15'h0, wake_o}, 16'h1);
    wr(2'd3, 16'h8003);
    check("R6 pme clear alone holds", {15'h0, wake_o}, 16'h1);
    wr(2'd1, 16'h1);
    check("R6 one cycle late", {15'h0, wake_o}, 16'h1);
    @(negedge clk);
    check("R6 release by status", {15'h0, wake_o}, 16'h0);
    arm();
    @(negedge clk);
    check("R5 rearm", {15'h0, wake_o}, 16'h1);
    wr(2'd0, 16'h1);
    @(negedge clk);
    check("R6 release by assert bit", {15'h0, wake_o}, 16'h0);
    wr(2'd1, 16'h1);
    arm();
    @(negedge clk);
    check("R5 rearm 2", {15'h0, wake_o}, 16'h1);
    wr(2'd0, 16'h2);
    @(negedge clk);
    check("R6 release by enable", {15'h0, wake_o}, 16'h0);
    wr(2'd1, 16'h1);
    wr(2'd3, 16'h8000);
    rd(2'd3, 16'h0000, "R9 pme status cleared");
  endtask

  task automatic t_acpi();
    wr(2'd0, 16'h0);
    wr(2'd2, 16'h0005);
    rd(2'd2, 16'h0005, "R7 mask readback");
    pkt(1'b0, 1'b0, 1'b1, 4'h2, 1'b1);
    rd(2'd3, 16'h0000, "R7 masked filter");
    pkt(1'b0, 1'b0, 1'b0, 4'h4, 1'b1);
    rd(2'd3, 16'h0000, "R7 address fail");
    pkt(1'b0, 1'b1, 1'b1, 4'h4, 1'b1);
    rd(2'd3, 16'h0000, "R7 errored");
    pkt(1'b0, 1'b0, 1'b1, 4'h4, 1'b1);
    rd(2'd3, 16'h8000, "R7 both stages");
    @(negedge clk);
    check("R8 no enable no wake", {15'h0, wake_o}, 16'h0);
    wr(2'd3, 16'h0100);
    @(negedge clk);
    check("R8 enable drives wake", {15'h0, wake_o}, 16'h1);
    wr(2'd3, 16'h8100);
    @(negedge clk);
    check("R8 status clear drops wake", {15'h0, wake_o}, 16'h0);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_set_wins();
    wr(2'd0, 16'h1);
    pkt(1'b1, 1'b0, 1'b0, 4'h0, 1'b1);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_magic = 1'b1;
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h1;
    @(negedge clk);
    pkt_valid = 1'b0; pkt_magic = 1'b0; reg_wr = 1'b0;
    rd(2'd1, 16'h1, "R9 set wins");
    wr(2'd1, 16'h1);
    rd(2'd1, 16'h0, "R9 later clear");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_gated();
    t_status_only();
    t_apm_wake();
    t_acpi();
    t_set_wins();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule